// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block lets clocked logic use a 32K x 8 asynchronous static RAM. The host raises a request for a single byte, with a direction bit, an address and, for a write, a data byte. The block holds the request and drives the memory's active-low select, output-enable and write strobes. Each strobe stays in its state for a number of clock cycles. That number comes from the memory's nanosecond timing figures and the clock period, rounded up to whole cycles.

The memory's data pins are shared between directions. The block therefore presents them as a separate outgoing byte, a drive-enable and an incoming byte, which a pad ring joins into one bus. A read keeps select and output-enable low until the access time has passed. The incoming byte is captured on that edge, both strobes are released, and the address is held for one more cycle. A write drives the byte while select and write-enable are low, and the write ends when write-enable rises. The byte is still driven for one cycle after that rise. A write that follows a read first waits out the memory's output-float time with nothing driven.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, the three strobes are high, the drive-enable is low, `ready` is high and `done` is low.
- R2: A read holds select and output-enable low and write-enable high for max(ceil(tAA/tCLK), ceil(tDOE/tCLK)) cycles, which is 6 cycles by default. `rdata` is then the memory byte at the address, and `done` goes high 7 cycles after the accepting edge.
- R3: A write holds write-enable low (with select low) for max(ceil(tPWE/tCLK), ceil(tAW/tCLK), ceil(tSD/tCLK)) cycles, which is 5 by default. `done` rises 6 cycles after the accepting edge when no read came before the write.
- R4: The drive-enable is high only from the first write-enable-low cycle through the single cycle that follows the write-enable rising edge. It is still high in the cycle where write-enable rises, so the memory latches the driven byte.
- R5: The address pins change only on an accepting edge. They stay stable from that edge until at least one cycle after select is released.
- R6: After output-enable rises, the drive-enable stays low for more than ceil(tHZ/tCLK) cycles, which is 2 by default. A write accepted while the previous operation was a read has `done` 8 cycles after the accepting edge.
- R7: The drive-enable is never high in a cycle where output-enable is low.
- R8: A request is taken only when `ready` is high. `ready` is low while an operation runs, and a request raised then is dropped with no effect on the memory.
- R9: `done` is a single-cycle pulse, one per accepted request.
- R10: Write-enable is low only while select is low and output-enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, taken when `ready` is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte captured by the last read |
| mem_addr | output | 15 | Memory address pins |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dout | output | 8 | Byte to drive onto the shared I/O |
| mem_dout_en | output | 1 | Drive-enable for the shared I/O |
| mem_din | input | 8 | Byte read from the shared I/O |

## Verification
If the state register or the interval counter goes wrong, the `done` latency changes from its fixed value of 6, 7 or 8 cycles, and the bench sees this within the same operation. A read sampled too early returns the idle filler byte instead of stored data. A write-enable pulse that is short or badly placed either stores the wrong byte or sends the rising edge while the bus is undriven. A missing turnaround shows up as drive-enable rising within two cycles of output-enable, which the bus monitor reports on that cycle.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TURN  = 3'd1,
    ST_RD    = 3'd2,
    ST_RDREL = 3'd3,
    ST_WP    = 3'd4,
    ST_WH    = 3'd5,
    ST_WREC  = 3'd6
  } seq_state_e;

  // Whole clock cycles covering a minimum interval, rounded up.
  function automatic int cyc_of(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q, cnt_nx;

  always_comb begin
    if (load)             cnt_nx = load_val;
    else if (cnt_q != '0) cnt_nx = cnt_q - 1'b1;
    else                  cnt_nx = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_hold.sv
module sram_seq_hold #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic          in_we,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          q_we,
  output logic [AW-1:0] q_addr,
  output logic [DW-1:0] q_wdata,
  output logic [DW-1:0] q_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_we    <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
    end else if (accept) begin
      q_we    <= in_we;
      q_addr  <= in_addr;
      q_wdata <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_rdata <= '0;
    else if (capture) q_rdata <= bus_rdata;
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_AA_NS   = 55,
  parameter int T_DOE_NS  = 25,
  parameter int T_PWE_NS  = 40,
  parameter int T_AW_NS   = 45,
  parameter int T_SD_NS   = 25,
  parameter int T_WC_NS   = 55,
  parameter int T_HZ_NS   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din
);
  localparam int N_RD  = max2(max2(cyc_of(T_AA_NS, CLK_NS), cyc_of(T_DOE_NS, CLK_NS)), 1);
  localparam int N_WP  = max2(max2(cyc_of(T_PWE_NS, CLK_NS), cyc_of(T_AW_NS, CLK_NS)),
                              max2(cyc_of(T_SD_NS, CLK_NS), 1));
  localparam int N_WC  = cyc_of(T_WC_NS, CLK_NS);
  localparam int N_REC = max2(N_WC - N_WP - 1, 0);
  localparam int N_TA  = max2(cyc_of(T_HZ_NS, CLK_NS), 1);
  localparam int N_MAX = max2(max2(N_RD, N_WP), max2(N_REC, N_TA));
  localparam int CW    = $clog2(N_MAX + 1);

  seq_state_e    st_q, st_nx;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic          rd_last_q, done_q;
  logic          accept, capture, op_we;

  // Next-state decision
  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      ST_IDLE:  if (req) st_nx = !req_we ? ST_RD : (rd_last_q ? ST_TURN : ST_WP);
      ST_TURN:  if (tmr_zero) st_nx = ST_WP;
      ST_RD:    if (tmr_zero) st_nx = ST_RDREL;
      ST_RDREL: st_nx = ST_IDLE;
      ST_WP:    if (tmr_zero) st_nx = ST_WH;
      ST_WH:    st_nx = (N_REC > 0) ? ST_WREC : ST_IDLE;
      ST_WREC:  if (tmr_zero) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  // Interval length loaded on every state entry
  always_comb begin
    tmr_load = (st_nx != st_q);
    unique case (st_nx)
      ST_TURN: tmr_val = CW'(N_TA - 1);
      ST_RD:   tmr_val = CW'(N_RD - 1);
      ST_WP:   tmr_val = CW'(N_WP - 1);
      ST_WREC: tmr_val = CW'(max2(N_REC, 1) - 1);
      default: tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rd_last_q <= 1'b0;
    else if (st_q == ST_RDREL) rd_last_q <= 1'b1;
    else if (st_q == ST_WP)    rd_last_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= (st_q != ST_IDLE) && (st_nx == ST_IDLE);
  end

  assign accept  = (st_q == ST_IDLE) && req;
  assign capture = (st_q == ST_RD) && tmr_zero;

  sram_seq_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_seq_hold #(.AW(ADDR_W), .DW(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .in_we     (req_we),
    .in_addr   (req_addr),
    .in_wdata  (req_wdata),
    .bus_rdata (mem_din),
    .q_we      (op_we),
    .q_addr    (mem_addr),
    .q_wdata   (mem_dout),
    .q_rdata   (rdata)
  );

  // Strobe decode from the state register
  assign mem_ce_n    = !((st_q == ST_RD) || (st_q == ST_WP) || (st_q == ST_WH));
  assign mem_oe_n    = !(st_q == ST_RD);
  assign mem_we_n    = !((st_q == ST_WP) && op_we);
  assign mem_dout_en = (st_q == ST_WP) || (st_q == ST_WH);
  assign ready       = (st_q == ST_IDLE);
  assign done        = done_q;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
  parameter int AW     = 15,
  parameter int WP_CYC = 5,
  parameter int TA_CYC = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dout_en
);
  logic [7:0] wl_cnt, hz_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               wl_cnt <= '0;
    else if (mem_we_n)        wl_cnt <= '0;
    else if (wl_cnt != 8'hFF) wl_cnt <= wl_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hz_cnt <= 8'hFF;
    else if (!mem_oe_n)       hz_cnt <= '0;
    else if (hz_cnt != 8'hFF) hz_cnt <= hz_cnt + 1'b1;
  end

  // R3
  we_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wl_cnt >= 8'(WP_CYC)));

  // R4
  data_at_we_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dout_en);

  // R4
  data_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> !mem_dout_en);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |=> $stable(mem_addr));

  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> (hz_cnt > 8'(TA_CYC)));

  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dout_en);

  // R8
  busy_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(mem_addr));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  we_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.AW(ADDR_W), .WP_CYC(N_WP), .TA_CYC(N_TA)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ready       (ready),
  .done        (done),
  .mem_addr    (mem_addr),
  .mem_ce_n    (mem_ce_n),
  .mem_oe_n    (mem_oe_n),
  .mem_we_n    (mem_we_n),
  .mem_dout_en (mem_dout_en)
);

// File: tb/sim_sram_seq_ctrl.sv
module sim_sram_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NRD = 6;   // max(ceil(55/10), ceil(25/10))
  localparam int NWP = 5;   // max(ceil(40/10), ceil(45/10), ceil(25/10))
  localparam int NTA = 2;   // ceil(20/10)
  localparam int LAT_RD  = NRD + 1;
  localparam int LAT_WR  = NWP + 1;
  localparam int LAT_WAR = NTA + NWP + 1;

  logic        clk, rst_n, req, req_we;
  logic [14:0] req_addr;
  logic [7:0]  req_wdata, rdata, mem_dout, mem_din;
  logic        ready, done, mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en;
  logic [14:0] mem_addr;
  logic [7:0]  mem [256];

  int checks = 0, fails = 0;
  int hz = 100, wl = 0, done_cnt = 0;
  logic [14:0] cur_addr;
  logic        prev_rd = 1'b0;

  sram_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .done(done), .rdata(rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory model: outputs only when selected, output-enabled and not writing
  assign mem_din = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mem[mem_addr[7:0]] : 8'hEE;

  always @(posedge mem_we_n) begin
    if (rst_n && !mem_ce_n) begin
      if (!mem_dout_en) begin
        fails++;
        $display("FAIL R4: bus undriven at write end, actual en=0 expected en=1");
      end
      mem[mem_addr[7:0]] = mem_dout;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Bus monitors, sampled between edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (mem_dout_en && !mem_oe_n) begin
        fails++; $display("FAIL R7: actual drive with oe low, expected none");
      end
      if (mem_dout_en && hz <= NTA) begin
        fails++; $display("FAIL R6: actual drive %0d cycles after oe, expected > %0d", hz, NTA);
      end
      if (!mem_ce_n && mem_addr != cur_addr) begin
        fails++; $display("FAIL R5: actual addr %0h expected %0h", mem_addr, cur_addr);
      end
      if (mem_we_n && wl != 0 && wl < NWP) begin
        fails++; $display("FAIL R3: actual we low %0d expected >= %0d", wl, NWP);
      end
      if (!mem_we_n && (mem_ce_n || !mem_oe_n)) begin
        fails++; $display("FAIL R10: actual we low unqualified, expected ce low oe high");
      end
      hz = !mem_oe_n ? 0 : hz + 1;
      wl = !mem_we_n ? wl + 1 : 0;
    end
  end

  task automatic do_op(input logic we, input logic [14:0] a, input logic [7:0] wd,
                       input logic [7:0] exp_rd);
    int n = 0;
    int exp_lat;
    exp_lat = !we ? LAT_RD : (prev_rd ? LAT_WAR : LAT_WR);
    chk("R8 ready before request", int'(ready), 1);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    @(posedge clk);
    cur_addr = a;
    @(negedge clk);
    req = 1'b0;
    while (n < 40) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (done) break;
    end
    chk(we ? "R3/R6 write done latency" : "R2 read done latency", n, exp_lat);
    if (!we) chk("R2 read data", int'(rdata), int'(exp_rd));
    @(negedge clk);
    chk("R9 done single cycle", int'(done), 0);
    prev_rd = !we;
  endtask

  // {we, addr, wdata, expected read byte}
  localparam logic [31:0] VEC [10] = '{
    {1'b1, 15'h0012, 8'hA5, 8'h00},
    {1'b1, 15'h7F34, 8'h3C, 8'h00},
    {1'b0, 15'h0012, 8'h00, 8'hA5},
    {1'b0, 15'h7F34, 8'h00, 8'h3C},
    {1'b1, 15'h0012, 8'h5A, 8'h00},
    {1'b0, 15'h0012, 8'h00, 8'h5A},
    {1'b1, 15'h7FFF, 8'hFF, 8'h00},
    {1'b1, 15'h0000, 8'h00, 8'h00},
    {1'b0, 15'h7FFF, 8'h00, 8'hFF},
    {1'b0, 15'h0000, 8'h00, 8'h00}
  };

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : stim
    int d0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    cur_addr = '0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 ce_n", int'(mem_ce_n), 1);
    chk("R1 oe_n", int'(mem_oe_n), 1);
    chk("R1 we_n", int'(mem_we_n), 1);
    chk("R1 dout_en", int'(mem_dout_en), 0);
    chk("R1 ready", int'(ready), 1);
    chk("R1 done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", int'(ready), 1);

    for (int v = 0; v < 10; v++)
      do_op(VEC[v][31], VEC[v][30:16], VEC[v][15:8], VEC[v][7:0]);

    // R8: request during a read is dropped
    d0 = done_cnt;
    req = 1'b1; req_we = 1'b0; req_addr = 15'h0012;
    @(posedge clk); cur_addr = 15'h0012;
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    chk("R8 ready low while busy", int'(ready), 0);
    req = 1'b1; req_we = 1'b1; req_addr = 15'h0012; req_wdata = 8'h77;
    @(negedge clk); req = 1'b0;
    while (!done) @(negedge clk);
    chk("R2 read during ignore test", int'(rdata), 8'h5A);
    @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R9 one done per request", done_cnt - d0, 1);
    chk("R8 ready after ignored request", int'(ready), 1);
    prev_rd = 1'b1;
    do_op(1'b0, 15'h0012, 8'h00, 8'h5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule